// File: doc/BRIEF.md
# Execute-Ahead Deferral Controller

This controller lets a pipeline keep running past a long-latency operation such as a cache miss, a translation miss or a divide. A long-latency instruction in normal operation takes a checkpoint and starts an execute-ahead phase. The controller then decides, one instruction at a time, whether the instruction runs now or is parked in a small deferred queue. It decides from a per-register not-ready scoreboard. Parked instructions keep the operand values that were already known when they were parked.

When the primary operation completes, the controller stops taking new instructions. It replays the queue in order, one entry per cycle, as passes. An entry that still depends on a not-ready register goes back to the tail of the queue, and so does a secondary long-latency entry whose data is still outstanding. A pass with no such re-queue ends the speculation with a join. If the queue or the store buffer overflowed during execute-ahead, the phase keeps running as a scout until the primary operation completes. The controller then signals a failure, so that execution restarts from the checkpoint.

The phase is shown on `phase` as normal (0), execute-ahead (1), replay (2), join (3) and fail (4).

Top module: `ea_defer_ctrl`

## Requirements
- R1: After reset, `phase` is 0, the queue is empty, no register is marked not-ready, `in_ready` is 1, and `exec_valid` and all three strobes are 0.
- R2: In phase 0, an accepted instruction without `in_ll` drives `exec_valid` in the same cycle with `exec_replay`=0, `exec_fetch`=0 and its own opcode, destination and values. In phase 0, `ll_done` and `sb_ovf` have no effect.
- R3: In phase 0, an accepted instruction with `in_ll` raises `ckpt_stb` in the same cycle and is not executed. It is queued, its destination is marked not-ready, and `phase` is 1 from the next cycle.
- R4: In phase 1, an accepted instruction is deferred (no `exec_valid`) and its destination is marked not-ready if either source register is not-ready or `in_ll` is set.
- R5: In phase 1, an accepted instruction with both sources ready and no `in_ll` executes in the same cycle, and it clears the not-ready mark of its destination.
- R6: A queued entry keeps the values of the sources that were ready when it was deferred. On replay, `exec_fetch` bit 0 (source 0) or bit 1 (source 1) is 1 for a source that was not-ready, and that value field reads 0. A bit of 0 means that the stored value is valid.
- R7: `ll_done` in phase 1 with no overflow recorded gives `phase` 2 in the next cycle. In phase 2, `in_ready` is 0 and queued entries come out in the order they were queued, with `exec_replay`=1.
- R8: In replay, an entry is queued again at the tail and its destination marked not-ready in two cases. The first is a source flagged in `exec_fetch` that is still not-ready. The second is an entry that was a secondary long-latency instruction (one with `in_ll` accepted in phase 1) while `ll_busy` is 1. A pass covers the entries present at its start. Another pass follows while any entry was queued again.
- R9: A pass with no entry queued again leads to one cycle of `phase` 3 with `join_stb`=1, then `phase` 0 with an empty queue.
- R10: In phase 1, a deferral while the queue holds DEPTH (16) entries, or an `sb_ovf` pulse, records an overflow. Independent instructions keep executing. The next `ll_done` then gives one cycle of `phase` 4 with `fail_stb`=1 instead of replay. This clears the queue and every not-ready mark, and `phase` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | OP_W | Opcode |
| in_dst | input | RW | Destination register |
| in_src0 | input | RW | Source register 0 |
| in_src1 | input | RW | Source register 1 |
| in_val0 | input | DW | Value of source 0 when ready |
| in_val1 | input | DW | Value of source 1 when ready |
| in_ll | input | 1 | Instruction is long-latency |
| ll_done | input | 1 | Primary long-latency operation completed |
| ll_busy | input | 1 | Secondary long-latency data still outstanding |
| sb_ovf | input | 1 | Store buffer overflow |
| in_ready | output | 1 | Normal stream accepted this cycle |
| exec_valid | output | 1 | Instruction issued to execution |
| exec_replay | output | 1 | Issued instruction comes from the queue |
| exec_op | output | OP_W | Issued opcode |
| exec_dst | output | RW | Issued destination |
| exec_src0 | output | RW | Issued source 0 |
| exec_src1 | output | RW | Issued source 1 |
| exec_val0 | output | DW | Captured or live value of source 0 |
| exec_val1 | output | DW | Captured or live value of source 1 |
| exec_fetch | output | 2 | Sources to be read from the register file |
| ckpt_stb | output | 1 | Take a checkpoint |
| join_stb | output | 1 | Commit speculative state |
| fail_stb | output | 1 | Discard speculation, restart from checkpoint |
| phase | output | 3 | Current phase |

## Verification
A wrong not-ready bit appears at the ports in the same cycle as the next instruction that reads that register. Such an instruction executes when it should defer, or defers when it should execute, and `exec_valid` shows it at once. A corrupted queue entry or pointer appears only during replay, as a wrong opcode, a wrong destination, a captured value in the wrong field or a wrong order. An entry that is lost or duplicated shows up as a missing or extra replay issue before the join. A pass counter or re-queue flag that is off shows up as a join that comes too early while `ll_busy` is still high, or as a replay that never ends. A stale overflow flag shows up as `fail_stb` in place of `join_stb`, or the reverse, on the next completion.

// File: rtl/ea_defer_ctrl.sv
module ea_defer_ctrl #(
  parameter int NREG  = 32,
  parameter int OP_W  = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int RW = $clog2(NREG),
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OP_W-1:0] in_op,
  input  logic [RW-1:0]   in_dst,
  input  logic [RW-1:0]   in_src0,
  input  logic [RW-1:0]   in_src1,
  input  logic [DW-1:0]   in_val0,
  input  logic [DW-1:0]   in_val1,
  input  logic            in_ll,
  input  logic            ll_done,
  input  logic            ll_busy,
  input  logic            sb_ovf,
  output logic            in_ready,
  output logic            exec_valid,
  output logic            exec_replay,
  output logic [OP_W-1:0] exec_op,
  output logic [RW-1:0]   exec_dst,
  output logic [RW-1:0]   exec_src0,
  output logic [RW-1:0]   exec_src1,
  output logic [DW-1:0]   exec_val0,
  output logic [DW-1:0]   exec_val1,
  output logic [1:0]      exec_fetch,
  output logic            ckpt_stb,
  output logic            join_stb,
  output logic            fail_stb,
  output logic [2:0]      phase
);
  typedef enum logic [2:0] {S_NS = 3'd0, S_EA = 3'd1, S_RP = 3'd2, S_JN = 3'd3, S_FL = 3'd4} st_t;
  st_t st;

  logic [NREG-1:0] na;
  logic [OP_W-1:0] q_op [DEPTH];
  logic [RW-1:0]   q_dst [DEPTH], q_s0 [DEPTH], q_s1 [DEPTH];
  logic [DW-1:0]   q_v0 [DEPTH], q_v1 [DEPTH];
  logic [1:0]      q_m [DEPTH];
  logic            q_ll [DEPTH];
  logic [PW-1:0]   hd, tl;
  logic [CW-1:0]   cnt, pass_cnt;
  logic            redef, ovf, wb_pend;

  logic [OP_W-1:0] h_op;
  logic [RW-1:0]   h_dst, h_s0, h_s1;
  logic [DW-1:0]   h_v0, h_v1;
  logic [1:0]      h_m;
  logic            h_ll;

  wire       acc      = in_valid && in_ready;
  wire [1:0] in_mask  = {na[in_src1], na[in_src0]};
  wire       q_full   = cnt == CW'(DEPTH);
  wire       want_def = acc && (in_ll || (st == S_EA && in_mask != 2'b00));
  wire       push_n   = want_def && !q_full;
  wire       drop     = want_def && q_full;

  wire rd      = st == S_RP && !wb_pend && pass_cnt != '0;
  wire h_na    = (q_m[hd][0] && na[q_s0[hd]]) || (q_m[hd][1] && na[q_s1[hd]]) || (q_ll[hd] && ll_busy);
  wire rp_exec = rd && !h_na;
  wire rp_def  = rd && h_na;
  wire wb      = st == S_RP && wb_pend;
  wire wr      = push_n || wb;

  assign in_ready    = st == S_NS || st == S_EA;
  assign ckpt_stb    = acc && in_ll && st == S_NS;
  assign join_stb    = st == S_JN;
  assign fail_stb    = st == S_FL;
  assign phase       = st;
  assign exec_replay = rp_exec;
  assign exec_valid  = (acc && !want_def) || rp_exec;
  assign exec_op     = st == S_RP ? q_op[hd]  : in_op;
  assign exec_dst    = st == S_RP ? q_dst[hd] : in_dst;
  assign exec_src0   = st == S_RP ? q_s0[hd]  : in_src0;
  assign exec_src1   = st == S_RP ? q_s1[hd]  : in_src1;
  assign exec_val0   = st == S_RP ? q_v0[hd]  : in_val0;
  assign exec_val1   = st == S_RP ? q_v1[hd]  : in_val1;
  assign exec_fetch  = st == S_RP ? q_m[hd]   : 2'b00;

  always_ff @(posedge clk) begin
    if (wr) begin
      q_op[tl]  <= wb ? h_op  : in_op;
      q_dst[tl] <= wb ? h_dst : in_dst;
      q_s0[tl]  <= wb ? h_s0  : in_src0;
      q_s1[tl]  <= wb ? h_s1  : in_src1;
      q_v0[tl]  <= wb ? h_v0  : (in_mask[0] ? '0 : in_val0);
      q_v1[tl]  <= wb ? h_v1  : (in_mask[1] ? '0 : in_val1);
      q_m[tl]   <= wb ? h_m   : in_mask;
      q_ll[tl]  <= wb ? h_ll  : (in_ll && st == S_EA);
    end
    if (rp_def) begin
      h_op <= q_op[hd]; h_dst <= q_dst[hd]; h_s0 <= q_s0[hd]; h_s1 <= q_s1[hd];
      h_v0 <= q_v0[hd]; h_v1 <= q_v1[hd]; h_m  <= q_m[hd];   h_ll <= q_ll[hd];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st == S_FL) begin
      na <= '0;
    end else begin
      if (want_def)             na[in_dst]   <= 1'b1;
      else if (acc)             na[in_dst]   <= 1'b0;
      if (rp_def)               na[q_dst[hd]] <= 1'b1;
      else if (rp_exec)         na[q_dst[hd]] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_NS; hd <= '0; tl <= '0; cnt <= '0; pass_cnt <= '0;
      redef <= 1'b0; ovf <= 1'b0; wb_pend <= 1'b0;
    end else begin
      if (wr) tl <= (tl == PW'(DEPTH - 1)) ? '0 : tl + 1'b1;
      if (rd) hd <= (hd == PW'(DEPTH - 1)) ? '0 : hd + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(rd);
      unique case (st)
        S_NS: begin
          ovf <= 1'b0;
          if (ckpt_stb) st <= S_EA;
        end
        S_EA: begin
          if (sb_ovf || drop) ovf <= 1'b1;
          if (ll_done) begin
            st       <= (ovf || sb_ovf || drop) ? S_FL : S_RP;
            pass_cnt <= cnt + CW'(push_n);
            redef    <= 1'b0;
          end
        end
        S_RP: begin
          if (rd) pass_cnt <= pass_cnt - 1'b1;
          if (rp_def) begin
            redef   <= 1'b1;
            wb_pend <= 1'b1;
          end
          if (wb_pend) wb_pend <= 1'b0;
          if (!wb_pend && pass_cnt == '0) begin
            if (redef) begin
              pass_cnt <= cnt;
              redef    <= 1'b0;
            end else begin
              st <= S_JN;
            end
          end
        end
        S_JN: st <= S_NS;
        S_FL: begin
          st <= S_NS; hd <= '0; tl <= '0; cnt <= '0; ovf <= 1'b0; wb_pend <= 1'b0;
        end
        default: st <= S_NS;
      endcase
    end
  end
endmodule

// File: rtl/ea_defer_ctrl_chk.sv
module ea_defer_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    phase,
  input logic          in_ready,
  input logic          ckpt_stb,
  input logic          join_stb,
  input logic          fail_stb,
  input logic          exec_replay,
  input logic [CW-1:0] q_cnt
);
  assert_ckpt_enters_ea_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_stb |=> phase == 3'd1);
  assert_no_intake_in_replay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 3'd2 |-> !in_ready);
  assert_replay_issue_in_replay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_replay |-> phase == 3'd2);
  assert_join_after_replay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    join_stb |-> $past(phase) == 3'd2);
  assert_join_returns_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    join_stb |=> phase == 3'd0 && q_cnt == '0);
  assert_fail_clears_queue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_stb |=> phase == 3'd0 && q_cnt == '0);
  assert_fail_after_ea_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_stb |-> $past(phase) == 3'd1);
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(DEPTH));
  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ckpt_stb, join_stb, fail_stb}));
endmodule

bind ea_defer_ctrl ea_defer_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .in_ready(in_ready),
  .ckpt_stb(ckpt_stb), .join_stb(join_stb), .fail_stb(fail_stb),
  .exec_replay(exec_replay), .q_cnt(cnt)
);

// File: tb/tb_ea_defer_ctrl.sv
module tb_ea_defer_ctrl;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ll = 0, ll_done = 0, ll_busy = 0, sb_ovf = 0;
  logic [7:0] in_op = 0;
  logic [4:0] in_dst = 0, in_src0 = 0, in_src1 = 0;
  logic [15:0] in_val0 = 0, in_val1 = 0;
  logic in_ready, exec_valid, exec_replay, ckpt_stb, join_stb, fail_stb;
  logic [7:0] exec_op;
  logic [4:0] exec_dst, exec_src0, exec_src1;
  logic [15:0] exec_val0, exec_val1;
  logic [1:0] exec_fetch;
  logic [2:0] phase;

  ea_defer_ctrl dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int n_ckpt = 0, n_join = 0, n_fail = 0;
  logic [47:0] exp_q [$];

  function automatic logic [47:0] mk(logic rep, logic [7:0] op, logic [4:0] d, logic [1:0] f,
                                     logic [15:0] v0, logic [15:0] v1);
    return {rep, op, d, f, v0, v1};
  endfunction

  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (ckpt_stb) n_ckpt++;
    if (join_stb) n_join++;
    if (fail_stb) n_fail++;
    if (exec_valid) begin
      logic [47:0] act;
      act = mk(exec_replay, exec_op, exec_dst, exec_fetch, exec_val0, exec_val1);
      if (exp_q.size() == 0) chk(0, "R7 unexpected issue", {16'h0, act}, 0);
      else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        chk(act == e, "R6/R7 issued item", {16'h0, act}, {16'h0, e});
      end
    end
  end

  task automatic send(input logic [7:0] op, input logic [4:0] d, s0, s1,
                      input logic [15:0] v0, v1, input logic ll, input logic ex, input string tag);
    if (ex) exp_q.push_back(mk(0, op, d, 2'b00, v0, v1));
    in_valid = 1; in_op = op; in_dst = d; in_src0 = s0; in_src1 = s1;
    in_val0 = v0; in_val1 = v1; in_ll = ll;
    @(negedge clk);
    chk(exec_valid == ex, tag, exec_valid, ex);
    @(posedge clk); #1;
    in_valid = 0; in_ll = 0;
  endtask

  task automatic pulse_done(input logic busy);
    ll_busy = busy; ll_done = 1;
    @(posedge clk); #1;
    ll_done = 0;
  endtask

  task automatic wait_phase(input logic [2:0] p, input string tag);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (phase == p) break;
    end
    chk(phase == p, tag, phase, p);
    @(posedge clk); #1;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c0, j0, f0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(phase == 0 && in_ready && !exec_valid, "R1 reset state", {phase, in_ready, exec_valid}, 3'b0_1_0);
    chk(!ckpt_stb && !join_stb && !fail_stb, "R1 strobes", {ckpt_stb, join_stb, fail_stb}, 0);
    @(posedge clk); #1;

    // R2: normal execution and ignored inputs in phase 0
    send(8'h10, 5'd3, 5'd1, 5'd2, 16'h1234, 16'h5678, 0, 1, "R2 normal issue");
    ll_done = 1; sb_ovf = 1; @(posedge clk); #1; ll_done = 0; sb_ovf = 0;
    @(negedge clk);
    chk(phase == 0 && in_ready, "R2 ll_done ignored", phase, 0);
    @(posedge clk); #1;

    // R3..R6, R7, R9: single replay pass
    c0 = n_ckpt; j0 = n_join; f0 = n_fail;
    send(8'h01, 5'd8, 5'd2, 5'd3, 16'h0a0a, 16'h0b0b, 1, 0, "R3 miss not issued");
    chk(n_ckpt == c0 + 1, "R3 checkpoint", n_ckpt - c0, 1);
    chk(phase == 1, "R3 phase", phase, 1);
    send(8'h02, 5'd10, 5'd8, 5'd3, 16'h1111, 16'h0055, 0, 0, "R4 dependent deferred");
    send(8'h03, 5'd12, 5'd1, 5'd2, 16'h3333, 16'h4444, 0, 1, "R5 independent issued");
    send(8'h04, 5'd14, 5'd4, 5'd10, 16'h0777, 16'h2222, 0, 0, "R4 chain deferred");
    send(8'h05, 5'd5, 5'd8, 5'd6, 16'h0000, 16'h0606, 0, 0, "R4 defer marks r5");
    send(8'h06, 5'd5, 5'd6, 5'd7, 16'h6666, 16'h7777, 0, 1, "R5 overwrite r5");
    send(8'h07, 5'd6, 5'd5, 5'd5, 16'h5555, 16'h5555, 0, 1, "R5 r5 now ready");
    exp_q.push_back(mk(1, 8'h01, 5'd8, 2'b00, 16'h0a0a, 16'h0b0b));
    exp_q.push_back(mk(1, 8'h02, 5'd10, 2'b01, 16'h0000, 16'h0055));
    exp_q.push_back(mk(1, 8'h04, 5'd14, 2'b10, 16'h0777, 16'h0000));
    exp_q.push_back(mk(1, 8'h05, 5'd5, 2'b01, 16'h0000, 16'h0606));
    pulse_done(0);
    @(negedge clk);
    chk(phase == 2 && !in_ready, "R7 replay entered", {phase, in_ready}, 4'b010_0);
    @(posedge clk); #1;
    wait_phase(0, "R9 back to normal");
    chk(n_join == j0 + 1 && n_fail == f0, "R9 one join", n_join - j0, 1);
    chk(exp_q.size() == 0, "R7 all replayed", exp_q.size(), 0);

    // R8: multiple passes while a secondary miss is outstanding
    j0 = n_join;
    send(8'h21, 5'd20, 5'd1, 5'd2, 16'h2101, 16'h2102, 1, 0, "R3 primary miss");
    send(8'h22, 5'd21, 5'd3, 5'd4, 16'h2201, 16'h2202, 1, 0, "R4 secondary miss");
    send(8'h23, 5'd22, 5'd21, 5'd4, 16'h2301, 16'h2302, 0, 0, "R4 on secondary");
    exp_q.push_back(mk(1, 8'h21, 5'd20, 2'b00, 16'h2101, 16'h2102));
    pulse_done(1);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(phase == 2 && n_join == j0, "R8 replay loops while busy", phase, 2);
    chk(exp_q.size() == 0, "R8 primary replayed", exp_q.size(), 0);
    exp_q.push_back(mk(1, 8'h22, 5'd21, 2'b00, 16'h2201, 16'h2202));
    exp_q.push_back(mk(1, 8'h23, 5'd22, 2'b01, 16'h0000, 16'h2302));
    @(posedge clk); #1 ll_busy = 0;
    wait_phase(0, "R8 final pass joins");
    chk(n_join == j0 + 1 && exp_q.size() == 0, "R9 join after passes", n_join - j0, 1);

    // R10: queue overflow, scout execution, fail
    f0 = n_fail; j0 = n_join;
    send(8'h30, 5'd1, 5'd0, 5'd0, 16'h0, 16'h0, 1, 0, "R3 miss before overflow");
    for (int i = 0; i < 15; i++)
      send(8'h40 + 8'(i), 5'd2, 5'd1, 5'd0, 16'h0, 16'h0, 0, 0, "R4 fill queue");
    send(8'h60, 5'd3, 5'd1, 5'd0, 16'h0, 16'h0, 0, 0, "R10 full drop");
    send(8'h61, 5'd9, 5'd4, 5'd4, 16'h0909, 16'h0909, 0, 1, "R10 scout executes");
    pulse_done(0);
    @(negedge clk);
    chk(fail_stb && phase == 4, "R10 fail strobe", {fail_stb, phase}, 4'b1_100);
    @(posedge clk); #1;
    wait_phase(0, "R10 back to normal");
    chk(n_fail == f0 + 1 && n_join == j0, "R10 fail not join", n_fail - f0, 1);
    send(8'h70, 5'd30, 5'd0, 5'd0, 16'h7070, 16'h7171, 1, 0, "R3 miss after fail");
    send(8'h71, 5'd11, 5'd1, 5'd3, 16'h0101, 16'h0303, 0, 1, "R10 marks cleared");
    exp_q.push_back(mk(1, 8'h70, 5'd30, 2'b00, 16'h7070, 16'h7171));
    pulse_done(0);
    wait_phase(0, "R10 queue cleared");
    chk(n_join == j0 + 1 && exp_q.size() == 0, "R10 only new entry", n_join - j0, 1);

    // R10: store-buffer overflow in phase 1 fails, in phase 0 ignored
    f0 = n_fail; j0 = n_join;
    send(8'h80, 5'd7, 5'd0, 5'd0, 16'h8080, 16'h8181, 1, 0, "R3 miss");
    sb_ovf = 1; @(posedge clk); #1; sb_ovf = 0;
    pulse_done(0);
    wait_phase(0, "R10 sb overflow done");
    chk(n_fail == f0 + 1 && n_join == j0, "R10 sb overflow fails", n_fail - f0, 1);
    sb_ovf = 1; @(posedge clk); #1; sb_ovf = 0;
    send(8'h90, 5'd7, 5'd0, 5'd0, 16'h9090, 16'h9191, 1, 0, "R3 miss");
    exp_q.push_back(mk(1, 8'h90, 5'd7, 2'b00, 16'h9090, 16'h9191));
    pulse_done(0);
    wait_phase(0, "R2 sb ignored then join");
    chk(n_fail == f0 + 1 && n_join == j0 + 1, "R2 sb_ovf in phase 0 ignored", n_join - j0, 1);
    chk(exp_q.size() == 0, "R7 nothing missing", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule